// File: doc/BRIEF.md
# I2C Byte-Level Bus Master

This block is an I2C master that a processor drives one byte at a time through a small register file on an 8-bit slave port with a strobe-and-acknowledge handshake. Software sets a clock divider, turns the core on, puts a byte in the transmit register and writes a command. One command can start the bus, move one byte in either direction with its acknowledge bit, and stop the bus. Polling the status register shows when the byte is done, what acknowledge the slave returned and whether the bus is occupied.

The clock and data lines are open drain. Each line has an input, an output that is always low, and an active-low output enable. A released line reads high through an external pull-up.

The design has three parts. A prescale counter gives one tick every `prescale+1` clocks. A bit engine runs each bus condition or bit in four phases, one phase per tick. Its states are IDLE, START, STOP, WRITE and READ. The bit engine goes from IDLE to the requested operation when it gets a go pulse. After the fourth phase it returns to IDLE and pulses done. A byte sequencer has the states IDLE, START, DATA, ACK and STOP:
- IDLE goes to START when the command has the start bit. Otherwise it goes to DATA when the command has read or write, or to STOP when it has only the stop bit.
- START goes to DATA when the command has read or write, otherwise to STOP or IDLE.
- DATA stays in DATA for eight bits and then goes to ACK.
- ACK goes to STOP when the stop bit was given, otherwise to IDLE.
- STOP goes to IDLE.

Each return to IDLE from a busy state raises the done flag.

Top module: `i2cm_core`

## Requirements
- R1: After reset the prescale reads 0xFFFF (address 0 low byte, address 1 high byte), control (address 2) reads 0x00, status (address 4) reads 0x00, and both line enables are high (released).
- R2: `wb_ack` rises in the cycle after a strobe is first seen, lasts exactly one clock, and occurs for every access at any address.
- R3: Prescale bytes can be written and read back. Control keeps only bit 7 (core enable) and bit 6 (interrupt enable) and reads the other bits as 0. At address 3 a write loads transmit and a read returns receive. At address 4 a write is a command and a read returns status.
- R4: A command with start (command bit 7) makes SDA fall while SCL is high. Status bit 6 (bus busy) then reads 1.
- R5: A command with write (command bit 4) shifts the transmit byte out MSB first, with SDA stable while SCL is high. The ninth-bit level sampled from the slave goes to status bit 7 (1 means not acknowledged).
- R6: A command with read (command bit 5) shifts a byte in MSB first into the receive register. On the ninth clock the master drives SDA low if command bit 3 is 0 and releases it if that bit is 1.
- R7: A command with stop (command bit 6) makes SDA rise while SCL is high. Afterwards both lines are released and status bit 6 reads 0.
- R8: Status bit 1 (transfer in progress) is 1 from the accepted command until the sequence ends. Status bit 0 (done) then sets and stays set until a command is written with bit 0 (flag clear) set.
- R9: While control bit 7 is 0, commands are ignored: no line is driven and status bits 1 and 0 stay 0.
- R10: SCL stays high for 2×(prescale+1) clock cycles per bit. The SCL period is 4×(prescale+1) cycles, so prescale = f_clk/(4·f_scl) − 1.
- R11: A command written while a transfer is in progress is ignored and produces no further bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_adr | input | 3 | Register address |
| wb_dat_i | input | 8 | Write data |
| wb_dat_o | output | 8 | Read data, valid with `wb_ack` |
| wb_we | input | 1 | 1 = write, 0 = read |
| wb_stb | input | 1 | Access strobe, held until acknowledged |
| wb_ack | output | 1 | One-cycle access acknowledge |
| scl_i | input | 1 | Level sensed on the clock line |
| scl_o | output | 1 | Clock line output value, always 0 |
| scl_oen | output | 1 | Clock line drive enable, active low |
| sda_i | input | 1 | Level sensed on the data line |
| sda_o | output | 1 | Data line output value, always 0 |
| sda_oen | output | 1 | Data line drive enable, active low |

## Verification
A wrong byte-sequencer state shows within one bit time at the ports, in three ways:
- an extra or missing SCL pulse;
- a byte received by the bench model that differs from the transmit register;
- a done flag that rises too early or never rises.

A wrong bit-engine phase shows as an SDA edge while SCL is high. The slave model reads that edge as a false start or stop, so its bit count resets and the received byte is corrupted by the end of that byte. Register-file faults appear on the very next read as a wrong value or a misplaced acknowledge.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    // register addresses
    localparam int ADR_PRE_LO = 0;
    localparam int ADR_PRE_HI = 1;
    localparam int ADR_CTRL   = 2;
    localparam int ADR_DATA   = 3;
    localparam int ADR_CMD    = 4;

    // command bit positions
    localparam int CB_STA  = 7;
    localparam int CB_STO  = 6;
    localparam int CB_RD   = 5;
    localparam int CB_WR   = 4;
    localparam int CB_NACK = 3;
    localparam int CB_IACK = 0;

    // control and status bit positions
    localparam int KB_EN   = 7;
    localparam int KB_IE   = 6;
    localparam int SB_RXNA = 7;
    localparam int SB_BUSY = 6;
    localparam int SB_TIP  = 1;
    localparam int SB_DONE = 0;

    typedef enum logic [2:0] {
        BIT_IDLE, BIT_START, BIT_STOP, BIT_WRITE, BIT_READ
    } bit_op_e;

    typedef enum logic [2:0] {
        BYTE_IDLE, BYTE_START, BYTE_DATA, BYTE_ACK, BYTE_STOP
    } byte_st_e;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [PW-1:0] prescale,
    output logic          tick
);
    logic [PW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (!en || cnt == '0)   cnt <= prescale;
        else                         cnt <= cnt - 1'b1;
    end

    assign tick = en && (cnt == '0);
endmodule

// File: rtl/i2cm_bitfsm.sv
module i2cm_bitfsm
    import i2cm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en,
    input  logic    tick,
    input  logic    go,
    input  bit_op_e op,
    input  logic    din,
    input  logic    sda_s,
    output logic    done,
    output logic    dout,
    output logic    scl_oen,
    output logic    sda_oen
);
    bit_op_e    st;
    logic [1:0] ph;
    logic       din_q, scl_low, sda_low, scl_n, sda_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= BIT_IDLE;
            ph      <= '0;
            din_q   <= 1'b1;
            scl_low <= 1'b0;
            sda_low <= 1'b0;
            done    <= 1'b0;
            dout    <= 1'b1;
        end else begin
            done <= 1'b0;
            if (!en) begin
                st      <= BIT_IDLE;
                ph      <= '0;
                scl_low <= 1'b0;
                sda_low <= 1'b0;
            end else if (st == BIT_IDLE) begin
                if (go) begin
                    st    <= op;
                    din_q <= din;
                    ph    <= '0;
                end
            end else if (tick) begin
                scl_low <= scl_n;
                sda_low <= sda_n;
                if (st == BIT_READ && ph == 2'd2) dout <= sda_s;
                if (ph == 2'd3) begin
                    st   <= BIT_IDLE;
                    done <= 1'b1;
                end
                ph <= ph + 2'd1;
            end
        end
    end

    // line drive for the phase being entered
    always_comb begin
        scl_n = scl_low;
        sda_n = sda_low;
        unique case (st)
            BIT_IDLE: ;
            BIT_START: begin
                case (ph)
                    2'd0:    sda_n = 1'b0;
                    2'd1:    scl_n = 1'b0;
                    2'd2:    sda_n = 1'b1;
                    default: scl_n = 1'b1;
                endcase
            end
            BIT_STOP: begin
                case (ph)
                    2'd0: begin scl_n = 1'b1; sda_n = 1'b1; end
                    2'd1:    scl_n = 1'b0;
                    2'd2:    sda_n = 1'b0;
                    default: ;
                endcase
            end
            BIT_WRITE, BIT_READ: begin
                case (ph)
                    2'd0: begin
                        scl_n = 1'b1;
                        sda_n = (st == BIT_WRITE) ? ~din_q : 1'b0;
                    end
                    2'd1:    scl_n = 1'b0;
                    2'd2:    ;
                    default: scl_n = 1'b1;
                endcase
            end
        endcase
    end

    assign scl_oen = ~scl_low;
    assign sda_oen = ~sda_low;
endmodule

// File: rtl/i2cm_bytefsm.sv
module i2cm_bytefsm
    import i2cm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          go,
    input  logic          c_sta,
    input  logic          c_sto,
    input  logic          c_rd,
    input  logic          c_wr,
    input  logic          c_nack,
    input  logic [DW-1:0] txd,
    input  logic          bit_done,
    input  logic          bit_dout,
    output logic          bit_go,
    output bit_op_e       bit_op,
    output logic          bit_din,
    output logic          tip,
    output logic          done,
    output logic          rxack,
    output logic [DW-1:0] rxd
);
    localparam int CW = $clog2(DW);

    byte_st_e      st;
    logic          issued, sto_q, rd_q, wr_q, nack_q;
    logic [CW-1:0] cnt;
    logic [DW-1:0] sr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= BYTE_IDLE; issued <= 1'b0; done <= 1'b0;
            sto_q <= 1'b0; rd_q <= 1'b0; wr_q <= 1'b0; nack_q <= 1'b0;
            cnt <= '0; sr <= '0; rxd <= '0; rxack <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!en) begin
                st     <= BYTE_IDLE;
                issued <= 1'b0;
            end else if (st == BYTE_IDLE) begin
                if (go) begin
                    sto_q  <= c_sto;
                    rd_q   <= c_rd;
                    wr_q   <= c_wr;
                    nack_q <= c_nack;
                    sr     <= txd;
                    cnt    <= CW'(DW - 1);
                    issued <= 1'b0;
                    if (c_sta)             st <= BYTE_START;
                    else if (c_rd || c_wr) st <= BYTE_DATA;
                    else if (c_sto)        st <= BYTE_STOP;
                end
            end else if (!issued) begin
                issued <= 1'b1;
            end else if (bit_done) begin
                issued <= 1'b0;
                case (st)
                    BYTE_START: begin
                        if (rd_q || wr_q) st <= BYTE_DATA;
                        else if (sto_q)   st <= BYTE_STOP;
                        else begin st <= BYTE_IDLE; done <= 1'b1; end
                    end
                    BYTE_DATA: begin
                        sr <= {sr[DW-2:0], rd_q ? bit_dout : 1'b0};
                        if (cnt == '0) st <= BYTE_ACK;
                        else           cnt <= cnt - 1'b1;
                    end
                    BYTE_ACK: begin
                        if (rd_q) rxd   <= sr;
                        else      rxack <= bit_dout;
                        if (sto_q) st <= BYTE_STOP;
                        else begin st <= BYTE_IDLE; done <= 1'b1; end
                    end
                    BYTE_STOP: begin
                        st   <= BYTE_IDLE;
                        done <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // requests to the bit engine
    always_comb begin
        bit_op  = BIT_IDLE;
        bit_din = 1'b1;
        unique case (st)
            BYTE_IDLE:  ;
            BYTE_START: bit_op = BIT_START;
            BYTE_STOP:  bit_op = BIT_STOP;
            BYTE_DATA: begin
                bit_op  = rd_q ? BIT_READ : BIT_WRITE;
                bit_din = sr[DW-1];
            end
            BYTE_ACK: begin
                bit_op  = rd_q ? BIT_WRITE : BIT_READ;
                bit_din = nack_q;
            end
        endcase
    end

    assign bit_go = (st != BYTE_IDLE) && !issued;
    assign tip    = (st != BYTE_IDLE);
endmodule

// File: rtl/i2cm_core.sv
module i2cm_core
    import i2cm_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] wb_adr,
    input  logic [DW-1:0] wb_dat_i,
    output logic [DW-1:0] wb_dat_o,
    input  logic          wb_we,
    input  logic          wb_stb,
    output logic          wb_ack,
    input  logic          scl_i,
    output logic          scl_o,
    output logic          scl_oen,
    input  logic          sda_i,
    output logic          sda_o,
    output logic          sda_oen
);
    localparam int PW = 2 * DW;

    logic [PW-1:0] pre_q;
    logic [DW-1:0] tx_q, rxd, status, rd_mux;
    logic          en_q, ie_q, done_q, busy_q, ack_q;
    logic          scl_m, scl_s, scl_p, sda_m, sda_s, sda_p;
    logic          acc, wr_acc, cmd_wr, iack, go, tip, seq_done, rxack;
    logic          tick, bit_go, bit_din, bit_done, bit_dout;
    bit_op_e       bit_op;

    assign acc    = wb_stb && !ack_q;
    assign wr_acc = acc && wb_we;
    assign cmd_wr = wr_acc && (wb_adr == AW'(ADR_CMD));
    assign iack   = cmd_wr && wb_dat_i[CB_IACK];
    assign go     = cmd_wr && en_q && !tip;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '1; tx_q <= '0; en_q <= 1'b0; ie_q <= 1'b0;
            ack_q <= 1'b0; wb_dat_o <= '0; done_q <= 1'b0; busy_q <= 1'b0;
            {scl_m, scl_s, scl_p, sda_m, sda_s, sda_p} <= '1;
        end else begin
            ack_q <= acc;
            if (acc && !wb_we) wb_dat_o <= rd_mux;
            if (wr_acc) begin
                if (wb_adr == AW'(ADR_PRE_LO)) pre_q[DW-1:0]  <= wb_dat_i;
                if (wb_adr == AW'(ADR_PRE_HI)) pre_q[PW-1:DW] <= wb_dat_i;
                if (wb_adr == AW'(ADR_DATA))   tx_q           <= wb_dat_i;
                if (wb_adr == AW'(ADR_CTRL)) begin
                    en_q <= wb_dat_i[KB_EN];
                    ie_q <= wb_dat_i[KB_IE];
                end
            end
            if (seq_done)  done_q <= 1'b1;
            else if (iack) done_q <= 1'b0;
            {scl_p, scl_s, scl_m} <= {scl_s, scl_m, scl_i};
            {sda_p, sda_s, sda_m} <= {sda_s, sda_m, sda_i};
            if (scl_s && scl_p && sda_p && !sda_s)      busy_q <= 1'b1;
            else if (scl_s && scl_p && !sda_p && sda_s) busy_q <= 1'b0;
        end
    end

    always_comb begin
        status          = '0;
        status[SB_RXNA] = rxack;
        status[SB_BUSY] = busy_q;
        status[SB_TIP]  = tip;
        status[SB_DONE] = done_q;
        case (wb_adr)
            AW'(ADR_PRE_LO): rd_mux = pre_q[DW-1:0];
            AW'(ADR_PRE_HI): rd_mux = pre_q[PW-1:DW];
            AW'(ADR_CTRL): begin
                rd_mux        = '0;
                rd_mux[KB_EN] = en_q;
                rd_mux[KB_IE] = ie_q;
            end
            AW'(ADR_DATA): rd_mux = rxd;
            AW'(ADR_CMD):  rd_mux = status;
            default:       rd_mux = '0;
        endcase
    end

    assign wb_ack = ack_q;
    assign scl_o  = 1'b0;
    assign sda_o  = 1'b0;

    i2cm_tick #(.PW(PW)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(en_q), .prescale(pre_q), .tick(tick)
    );

    i2cm_bytefsm #(.DW(DW)) u_byte (
        .clk(clk), .rst_n(rst_n), .en(en_q), .go(go),
        .c_sta(wb_dat_i[CB_STA]), .c_sto(wb_dat_i[CB_STO]),
        .c_rd(wb_dat_i[CB_RD]), .c_wr(wb_dat_i[CB_WR]),
        .c_nack(wb_dat_i[CB_NACK]), .txd(tx_q),
        .bit_done(bit_done), .bit_dout(bit_dout),
        .bit_go(bit_go), .bit_op(bit_op), .bit_din(bit_din),
        .tip(tip), .done(seq_done), .rxack(rxack), .rxd(rxd)
    );

    i2cm_bitfsm u_bit (
        .clk(clk), .rst_n(rst_n), .en(en_q), .tick(tick), .go(bit_go),
        .op(bit_op), .din(bit_din), .sda_s(sda_s),
        .done(bit_done), .dout(bit_dout), .scl_oen(scl_oen), .sda_oen(sda_oen)
    );
endmodule

// File: rtl/i2cm_core_chk.sv
module i2cm_core_chk (
    input logic clk,
    input logic rst_n,
    input logic wb_stb,
    input logic wb_ack,
    input logic core_en,
    input logic scl_oen,
    input logic sda_oen,
    input logic tip,
    input logic done,
    input logic iack
);
    assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack |=> !wb_ack);

    assert_ack_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_ack |-> $past(wb_stb));

    assert_off_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !core_en |=> (scl_oen && sda_oen));

    assert_end_sets_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tip) && core_en) |=> done);

    assert_done_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> $past(iack));
endmodule

bind i2cm_core i2cm_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wb_stb(wb_stb), .wb_ack(wb_ack),
    .core_en(en_q), .scl_oen(scl_oen), .sda_oen(sda_oen),
    .tip(tip), .done(done_q), .iack(iack)
);

// File: tb/i2cm_core_test.sv
module i2cm_core_test;
    localparam int P_LO = 0, P_HI = 1, P_CTRL = 2, P_DATA = 3, P_CMD = 4;
    localparam logic [7:0] K_STA = 8'h80, K_STO = 8'h40, K_RD = 8'h20,
                           K_WR = 8'h10, K_NACK = 8'h08, K_IACK = 8'h01;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b1;
    logic [2:0] adr = '0;
    logic [7:0] dat_i = '0;
    logic       we = 1'b0, stb = 1'b0;
    logic [7:0] dat_o;
    logic       ack, scl_o, scl_oen, sda_o, sda_oen;
    logic       slave_low = 1'b0;
    logic       scl_line, sda_line;

    assign scl_line = scl_oen ? 1'b1 : scl_o;
    assign sda_line = (sda_oen ? 1'b1 : sda_o) & ~slave_low;

    i2cm_core uut (
        .clk(clk), .rst_n(rst_n), .wb_adr(adr), .wb_dat_i(dat_i), .wb_dat_o(dat_o),
        .wb_we(we), .wb_stb(stb), .wb_ack(ack),
        .scl_i(scl_line), .scl_o(scl_o), .scl_oen(scl_oen),
        .sda_i(sda_line), .sda_o(sda_o), .sda_oen(sda_oen)
    );

    int n_chk = 0, n_err = 0, ack_bad = 0;
    bit finished = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // slave model
    int         bitcnt = 0, nbytes = 0;
    logic [7:0] rxsh = '0, got = '0, slave_tx = '0;
    logic       slave_rd = 1'b0, slave_ack_en = 1'b1, mack = 1'b1;

    always @(negedge sda_line) if (scl_line === 1'b1) bitcnt = 0;
    always @(posedge sda_line) if (scl_line === 1'b1) bitcnt = 0;
    always @(posedge scl_line) begin
        if (bitcnt < 8) begin
            rxsh = {rxsh[6:0], sda_line};
            if (bitcnt == 7 && !slave_rd) begin got = rxsh; nbytes++; end
        end else if (bitcnt == 8) mack = sda_line;
        bitcnt++;
    end
    always @(negedge scl_line) begin
        if (bitcnt == 9) bitcnt = 0;
        if (bitcnt < 8) slave_low = slave_rd & ~slave_tx[7-bitcnt];
        else            slave_low = ~slave_rd & slave_ack_en;
    end

    // SCL high-time monitor
    int hcnt = 0, last_high = 0;
    always @(negedge clk) begin
        if (scl_line === 1'b1) hcnt++;
        else begin
            if (hcnt != 0) last_high = hcnt;
            hcnt = 0;
        end
    end

    task automatic wb_write(input int a, input logic [7:0] d);
        @(negedge clk);
        if (ack) ack_bad++;
        adr = 3'(a); dat_i = d; we = 1'b1; stb = 1'b1;
        @(negedge clk);
        if (!ack) ack_bad++;
        stb = 1'b0; we = 1'b0;
        @(negedge clk);
        if (ack) ack_bad++;
    endtask

    task automatic wb_read(input int a, output logic [7:0] d);
        @(negedge clk);
        if (ack) ack_bad++;
        adr = 3'(a); we = 1'b0; stb = 1'b1;
        @(negedge clk);
        if (!ack) ack_bad++;
        d = dat_o; stb = 1'b0;
        @(negedge clk);
        if (ack) ack_bad++;
    endtask

    task automatic wait_idle(input string req);
        logic [7:0] s;
        s = 8'h02;
        for (int i = 0; i < 3000; i++) begin
            wb_read(P_CMD, s);
            if (!s[1]) break;
        end
        chk(req, 32'(s[1]), 0);
    endtask

    task automatic do_write(input logic [7:0] cmd, input logic [7:0] b, input logic ack_en);
        slave_ack_en = ack_en;
        wb_write(P_DATA, b);
        wb_write(P_CMD, cmd);
        wait_idle("R8 write finishes");
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, b, s;
        int cnt0;
        void'($urandom(32'd2024));
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        wb_read(P_LO, r);   chk("R1 prescale low", 32'(r), 32'hFF);
        wb_read(P_HI, r);   chk("R1 prescale high", 32'(r), 32'hFF);
        wb_read(P_CTRL, r); chk("R1 control", 32'(r), 0);
        wb_read(P_CMD, r);  chk("R1 status", 32'(r), 0);
        chk("R1 scl released", 32'(scl_oen), 1);
        chk("R1 sda released", 32'(sda_oen), 1);

        // R3 register access
        for (int i = 0; i < 4; i++) begin
            b = 8'($urandom);
            wb_write(P_LO, b); wb_read(P_LO, r); chk("R3 prescale low", 32'(r), 32'(b));
            b = 8'($urandom);
            wb_write(P_HI, b); wb_read(P_HI, r); chk("R3 prescale high", 32'(r), 32'(b));
            b = 8'($urandom) & 8'h7F;
            wb_write(P_CTRL, b); wb_read(P_CTRL, r); chk("R3 control mask", 32'(r), 32'(b & 8'h40));
        end
        wb_write(P_DATA, 8'hC3);
        wb_read(P_DATA, r); chk("R3 shared data address reads receive", 32'(r), 0);

        // R9 disabled core ignores commands
        wb_write(P_CTRL, 8'h00);
        wb_write(P_CMD, K_STA | K_WR);
        repeat (200) @(negedge clk);
        wb_read(P_CMD, r); chk("R9 status while disabled", 32'(r), 0);
        chk("R9 scl idle", 32'(scl_oen), 1);
        chk("R9 sda idle", 32'(sda_oen), 1);
        chk("R9 no byte seen", 32'(nbytes), 0);

        // enable, prescale 1
        wb_write(P_LO, 8'h01); wb_write(P_HI, 8'h00);
        wb_write(P_CTRL, 8'h80);

        // R4/R5/R8 directed start + write
        slave_ack_en = 1'b1;
        wb_write(P_DATA, 8'hA0);
        wb_write(P_CMD, K_STA | K_WR);
        wb_read(P_CMD, r); chk("R8 tip during transfer", 32'(r[1]), 1);
        wait_idle("R8 start+write finishes");
        wb_read(P_CMD, r);
        chk("R4 bus busy after start", 32'(r[6]), 1);
        chk("R5 acknowledged", 32'(r[7]), 0);
        chk("R8 done set", 32'(r[0]), 1);
        chk("R5 byte at slave", 32'(got), 32'hA0);
        repeat (50) @(negedge clk);
        wb_read(P_CMD, r); chk("R8 done held", 32'(r[0]), 1);
        wb_write(P_CMD, K_IACK);
        wb_read(P_CMD, r); chk("R8 done cleared by flag clear", 32'(r[0]), 0);

        // R5 random writes
        for (int i = 0; i < 5; i++) begin
            logic ae;
            b = 8'($urandom); ae = 1'($urandom);
            do_write(K_WR | K_IACK, b, ae);
            wb_read(P_CMD, r);
            chk("R5 byte at slave", 32'(got), 32'(b));
            chk("R5 ack bit in status", 32'(r[7]), 32'(!ae));
        end

        // R6 random reads
        for (int i = 0; i < 5; i++) begin
            logic nk;
            b = 8'($urandom); nk = 1'($urandom);
            slave_tx = b; slave_rd = 1'b1; slave_low = ~b[7];
            wb_write(P_CMD, K_RD | K_IACK | (nk ? K_NACK : 8'h00));
            wait_idle("R8 read finishes");
            wb_read(P_DATA, r);
            chk("R6 received byte", 32'(r), 32'(b));
            chk("R6 master ack level", 32'(mack), 32'(nk));
            slave_rd = 1'b0; slave_low = 1'b0;
        end

        // R11 command during transfer ignored
        slave_ack_en = 1'b1;
        cnt0 = nbytes;
        wb_write(P_DATA, 8'h5A);
        wb_write(P_CMD, K_WR | K_IACK);
        wb_write(P_DATA, 8'h33);
        wb_write(P_CMD, K_WR);
        wait_idle("R11 first transfer finishes");
        repeat (200) @(negedge clk);
        wb_read(P_CMD, r);
        chk("R11 tip stays low", 32'(r[1]), 0);
        chk("R11 one byte only", 32'(nbytes - cnt0), 1);
        chk("R11 byte content", 32'(got), 32'h5A);

        // R7 stop
        wb_write(P_CMD, K_STO | K_IACK);
        wait_idle("R7 stop finishes");
        repeat (10) @(negedge clk);
        wb_read(P_CMD, r);
        chk("R7 bus free", 32'(r[6]), 0);
        chk("R7 done", 32'(r[0]), 1);
        chk("R7 scl released", 32'(scl_oen), 1);
        chk("R7 sda released", 32'(sda_oen), 1);

        // R10 SCL high time with prescale 2, full start-write-stop
        wb_write(P_LO, 8'h02);
        b = 8'($urandom);
        do_write(K_STA | K_WR | K_STO | K_IACK, b, 1'b1);
        repeat (10) @(negedge clk);
        chk("R10 scl high time", 32'(last_high), 6);
        chk("R10 byte at slave", 32'(got), 32'(b));
        wb_read(P_CMD, s);
        chk("R7 bus free after combined command", 32'(s[6]), 0);

        chk("R2 ack timing on every access", 32'(ack_bad), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule